// File: doc/BRIEF.md
# Two-Step Converter Frame Sequencer

This block sequences one conversion frame of a two-step analog-to-digital converter. A coarse successive-approximation search comes first. An incremental modulator then resolves the residue that remains. Each frame opens with an input sampling interval. The sequencer then runs a binary search, one bit per clock with the most significant bit first, using a shared amplifier stage configured as a comparator. At the end of the search the coarse code is left on the capacitor feedback, so that the residue stays in place. The same stage is then handed to the modulator for the fine interval.

While the modulator is not running, the sequencer holds two resets: the reset that forces the ring oscillator into its fixed alternating phase pattern, and the reset of the phase detectors. The next conversion therefore starts from a known phase and carries no history from the previous one. A free-run input makes frames follow one another with no gap. When free-run is low, each frame needs a start pulse. A frame counter and an end-of-frame pulse let a downstream stage combine the coarse and fine results.

The comparator, the analog switches and the oscillator lie outside this block. They appear only as the decision input and the strobe and code outputs.

Top module: `zoom_frame_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters the sampling interval: `sampleEn` is 1, `cmpMode` and `modEn` are 0, `capCode` is 0 and `frameCount` is 0.
- R2: With the default parameters, an active frame lasts 25 cycles, counted as positions 0 to 24. `sampleEn` is high only at position 0, `cmpMode` only at positions 1 to 8, and `modEn` only at positions 9 to 24. At most one of the three is high in any cycle.
- R3: At SAR position k (k = 1..8), `capCode` shows the bits already decided, with trial bit 8-k set to 1 and every lower bit at 0. The search therefore runs from bit 7 down to bit 0.
- R4: If `cmpDecision` is 1 at the clock edge that ends a SAR cycle, the trial bit is kept. If it is 0, the trial bit is cleared. With an ideal comparator, `cmpDecision` = (input >= `capCode`), and the final code equals the input code.
- R5: `capCode` is 0 during the sampling interval. From the cycle after the last SAR decision it holds the final coarse code, through the whole fine interval and through any idle period, until the next sampling interval.
- R6: `oscAlignRst` and `pfdRst` are 1 in every cycle where `modEn` is 0, including idle, and 0 throughout the fine interval.
- R7: `fineClr` is a one-cycle pulse in the last SAR cycle (position 8) of each frame, and the fine interval follows it directly.
- R8: `frameDone` is 1 only at position 24. `frameCount` starts at 0 after reset, rises by one on the edge that ends position 24, and holds otherwise.
- R9: If `freeRun` is 1 at the end of a frame, the next cycle is position 0 of a new frame. If it is 0, the block goes idle with `sampleEn`, `cmpMode` and `modEn` all 0 until a cycle in which `start` or `freeRun` is 1; the cycle after that is position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| freeRun | input | 1 | 1: frames repeat back to back |
| start | input | 1 | Begins one frame while idle |
| cmpDecision | input | 1 | Comparator result for the current trial code |
| sampleEn | output | 1 | Sampling interval enable |
| cmpMode | output | 1 | Shared stage in comparator mode, oscillator off |
| modEn | output | 1 | Fine (modulator) interval enable |
| fineClr | output | 1 | One-cycle pulse before the fine interval starts |
| oscAlignRst | output | 1 | Forces the oscillator phase pattern while high |
| pfdRst | output | 1 | Phase detector reset |
| capCode | output | SAR_BITS | Capacitor feedback code |
| frameDone | output | 1 | Last cycle of a frame |
| frameCount | output | CNT_W | Completed frame count |

## Verification
The bench builds the block with its default parameters: one sampling cycle, eight SAR bits and sixteen fine cycles, giving a 25-cycle frame. With eight bits, every input code from 0 to 255 can be run through an ideal comparator, one frame each, back to back in free-run. Every strobe and every intermediate trial code is checked against its arithmetically expected frame position. Separate passes cover start-gated frames with idle gaps between them, and a reset applied in the middle of a search.

// File: rtl/zoom_frame_seq_pkg.sv
package zoom_frame_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SAMPLE,
    SEQ_SAR,
    SEQ_FINE
  } seqState_t;

  // strobes the control hands to the SAR datapath
  typedef struct packed {
    logic sample;
    logic sarStep;
    logic frameEnd;
  } sarCtl_t;

endpackage

// File: rtl/zoom_frame_seq_ctrl.sv
module zoom_frame_seq_ctrl
  import zoom_frame_seq_pkg::*;
#(
  parameter int SAMPLE_CYCLES = 1,
  parameter int SAR_BITS      = 8,
  parameter int FINE_CYCLES   = 16
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    freeRun,
  input  logic    start,
  output sarCtl_t dpCtl,
  output logic    sampleEn,
  output logic    cmpMode,
  output logic    modEn,
  output logic    fineClr,
  output logic    oscAlignRst,
  output logic    pfdRst,
  output logic    frameDone
);

  localparam int MAX_A   = (SAMPLE_CYCLES > SAR_BITS) ? SAMPLE_CYCLES : SAR_BITS;
  localparam int MAX_LEN = (MAX_A > FINE_CYCLES) ? MAX_A : FINE_CYCLES;
  localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SAR_LAST    = CNT_W'(SAR_BITS - 1);
  localparam logic [CNT_W-1:0] FINE_LAST   = CNT_W'(FINE_CYCLES - 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_SAMPLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (start || freeRun) state <= SEQ_SAMPLE;
          cnt <= '0;
        end
        SEQ_SAMPLE: begin
          if (cnt == SAMPLE_LAST) begin
            state <= SEQ_SAR;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_SAR: begin
          if (cnt == SAR_LAST) begin
            state <= SEQ_FINE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_FINE: begin
          if (cnt == FINE_LAST) begin
            state <= freeRun ? SEQ_SAMPLE : SEQ_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= SEQ_SAMPLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  logic inFine;
  assign inFine = (state == SEQ_FINE);

  assign sampleEn    = (state == SEQ_SAMPLE);
  assign cmpMode     = (state == SEQ_SAR);
  assign modEn       = inFine;
  assign fineClr     = (state == SEQ_SAR) && (cnt == SAR_LAST);
  assign oscAlignRst = !inFine;
  assign pfdRst      = !inFine;
  assign frameDone   = inFine && (cnt == FINE_LAST);

  assign dpCtl.sample   = (state == SEQ_SAMPLE);
  assign dpCtl.sarStep  = (state == SEQ_SAR);
  assign dpCtl.frameEnd = inFine && (cnt == FINE_LAST);

endmodule

// File: rtl/zoom_frame_seq_dp.sv
module zoom_frame_seq_dp
  import zoom_frame_seq_pkg::*;
#(
  parameter int SAR_BITS = 8,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  sarCtl_t             dpCtl,
  input  logic                cmpDecision,
  output logic [SAR_BITS-1:0] capCode,
  output logic [CNT_W-1:0]    frameCount
);

  localparam logic [SAR_BITS-1:0] MSB_MASK = {1'b1, {(SAR_BITS-1){1'b0}}};

  logic [SAR_BITS-1:0] sarReg;
  logic [SAR_BITS-1:0] trialMask;
  logic [SAR_BITS-1:0] trialCode;

  // one-hot pointer walks from MSB to LSB, one bit per SAR cycle
  always_ff @(posedge clk) begin
    if (rst || dpCtl.sample) trialMask <= MSB_MASK;
    else if (dpCtl.sarStep)  trialMask <= trialMask >> 1;
  end

  genvar gi;
  generate
    for (gi = 0; gi < SAR_BITS; gi++) begin : g_bit
      assign trialCode[gi] = sarReg[gi] | trialMask[gi];
      always_ff @(posedge clk) begin
        if (rst || dpCtl.sample)
          sarReg[gi] <= 1'b0;
        else if (dpCtl.sarStep && trialMask[gi])
          sarReg[gi] <= cmpDecision;
      end
    end
  endgenerate

  always_comb begin
    if (dpCtl.sample)       capCode = '0;
    else if (dpCtl.sarStep) capCode = trialCode;
    else                    capCode = sarReg;
  end

  always_ff @(posedge clk) begin
    if (rst)                 frameCount <= '0;
    else if (dpCtl.frameEnd) frameCount <= frameCount + 1'b1;
  end

endmodule

// File: rtl/zoom_frame_seq.sv
module zoom_frame_seq
  import zoom_frame_seq_pkg::*;
#(
  parameter int SAMPLE_CYCLES = 1,
  parameter int SAR_BITS      = 8,
  parameter int FINE_CYCLES   = 16,
  parameter int CNT_W         = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                freeRun,
  input  logic                start,
  input  logic                cmpDecision,
  output logic                sampleEn,
  output logic                cmpMode,
  output logic                modEn,
  output logic                fineClr,
  output logic                oscAlignRst,
  output logic                pfdRst,
  output logic [SAR_BITS-1:0] capCode,
  output logic                frameDone,
  output logic [CNT_W-1:0]    frameCount
);

  sarCtl_t dpCtl;

  zoom_frame_seq_ctrl #(
    .SAMPLE_CYCLES(SAMPLE_CYCLES),
    .SAR_BITS     (SAR_BITS),
    .FINE_CYCLES  (FINE_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .freeRun    (freeRun),
    .start      (start),
    .dpCtl      (dpCtl),
    .sampleEn   (sampleEn),
    .cmpMode    (cmpMode),
    .modEn      (modEn),
    .fineClr    (fineClr),
    .oscAlignRst(oscAlignRst),
    .pfdRst     (pfdRst),
    .frameDone  (frameDone)
  );

  zoom_frame_seq_dp #(
    .SAR_BITS(SAR_BITS),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .dpCtl      (dpCtl),
    .cmpDecision(cmpDecision),
    .capCode    (capCode),
    .frameCount (frameCount)
  );

endmodule

// File: rtl/zoom_frame_seq_chk.sv
module zoom_frame_seq_chk #(
  parameter int SAR_BITS = 8,
  parameter int CNT_W    = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                freeRun,
  input logic                sampleEn,
  input logic                cmpMode,
  input logic                modEn,
  input logic                fineClr,
  input logic                oscAlignRst,
  input logic                pfdRst,
  input logic [SAR_BITS-1:0] capCode,
  input logic                frameDone,
  input logic [CNT_W-1:0]    frameCount
);

  // R2
  phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sampleEn, cmpMode, modEn}));

  // R2
  sar_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmpMode) |-> $past(sampleEn));

  // R2
  fine_after_sar_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(modEn) |-> $past(cmpMode));

  // R7
  fine_clr_chk: assert property (@(posedge clk) disable iff (rst)
    fineClr |=> (modEn && !fineClr));

  // R6
  align_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(oscAlignRst) || $fell(pfdRst)) |-> $past(fineClr));

  // R5
  sample_code_chk: assert property (@(posedge clk) disable iff (rst)
    sampleEn |-> (capCode == '0));

  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (modEn && $past(modEn)) |-> $stable(capCode));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    frameDone |=> (frameCount == $past(frameCount) + 1'b1));

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frameDone |=> $stable(frameCount));

  // R9
  free_run_chk: assert property (@(posedge clk) disable iff (rst)
    (frameDone && freeRun) |=> sampleEn);

  // R9
  idle_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (frameDone && !freeRun) |=> !(sampleEn || cmpMode || modEn));

endmodule

bind zoom_frame_seq zoom_frame_seq_chk #(
  .SAR_BITS(SAR_BITS),
  .CNT_W   (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .freeRun    (freeRun),
  .sampleEn   (sampleEn),
  .cmpMode    (cmpMode),
  .modEn      (modEn),
  .fineClr    (fineClr),
  .oscAlignRst(oscAlignRst),
  .pfdRst     (pfdRst),
  .capCode    (capCode),
  .frameDone  (frameDone),
  .frameCount (frameCount)
);

// File: tb/zoom_frame_seq_tb.sv
module zoom_frame_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NBITS      = 8;
  localparam int FRAME      = 25;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             freeRun = 1'b0;
  logic             start = 1'b0;
  logic             cmpDecision;
  logic             sampleEn, cmpMode, modEn, fineClr, oscAlignRst, pfdRst, frameDone;
  logic [NBITS-1:0] capCode;
  logic [15:0]      frameCount;

  int  vin = 0;
  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // ideal comparator: keep the trial bit when the input is at or above it
  assign cmpDecision = (vin >= int'(capCode));

  zoom_frame_seq u_dut (
    .clk        (clk),
    .rst        (rst),
    .freeRun    (freeRun),
    .start      (start),
    .cmpDecision(cmpDecision),
    .sampleEn   (sampleEn),
    .cmpMode    (cmpMode),
    .modEn      (modEn),
    .fineClr    (fineClr),
    .oscAlignRst(oscAlignRst),
    .pfdRst     (pfdRst),
    .capCode    (capCode),
    .frameDone  (frameDone),
    .frameCount (frameCount)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // walk one whole frame from position 0, checking every output
  task automatic runFrame(input int val, input int cntBefore);
    for (int f = 0; f < FRAME; f++) begin
      int expCode;
      if (f == 0) vin = val;
      if (f == 0) expCode = 0;
      else if (f <= NBITS) begin
        int b = NBITS - f;
        expCode = (val & ~((1 << (b + 1)) - 1)) | (1 << b);
      end else expCode = val;
      check("R2 sampleEn", int'(sampleEn), int'(f == 0));
      check("R2 cmpMode", int'(cmpMode), int'(f >= 1 && f <= NBITS));
      check("R2 modEn", int'(modEn), int'(f > NBITS));
      check("R7 fineClr", int'(fineClr), int'(f == NBITS));
      check("R6 oscAlignRst", int'(oscAlignRst), int'(f <= NBITS));
      check("R6 pfdRst", int'(pfdRst), int'(f <= NBITS));
      check("R8 frameDone", int'(frameDone), int'(f == FRAME - 1));
      check("R8 frameCount", int'(frameCount), cntBefore);
      if (f == 0) check("R5 capCode sample", int'(capCode), 0);
      else if (f <= NBITS) check("R3 R4 capCode trial", int'(capCode), expCode);
      else check("R4 R5 capCode result", int'(capCode), val);
      step();
    end
  endtask

  task automatic checkIdle(input int n, input int code, input int cnt);
    for (int i = 0; i < n; i++) begin
      check("R9 idle sampleEn", int'(sampleEn), 0);
      check("R9 idle cmpMode", int'(cmpMode), 0);
      check("R9 idle modEn", int'(modEn), 0);
      check("R6 idle oscAlignRst", int'(oscAlignRst), 1);
      check("R6 idle pfdRst", int'(pfdRst), 1);
      check("R5 idle capCode", int'(capCode), code);
      check("R8 idle frameCount", int'(frameCount), cnt);
      step();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sampleEn", int'(sampleEn), 1);
    check("R1 cmpMode", int'(cmpMode), 0);
    check("R1 modEn", int'(modEn), 0);
    check("R1 capCode", int'(capCode), 0);
    check("R1 frameCount", int'(frameCount), 0);
    rst = 1'b0;

    // single start-gated frames with idle gaps (R9)
    runFrame(200, 0);
    checkIdle(6, 200, 1);
    start = 1'b1;
    check("R9 waits for clock", int'(sampleEn), 0);
    step();
    start = 1'b0;
    runFrame(77, 1);
    checkIdle(3, 77, 2);

    // free-running sweep of every input code (R2, R3, R4, R9)
    freeRun = 1'b1;
    step();
    for (int n = 0; n < (1 << NBITS); n++) runFrame(n, 2 + n);

    // reset in the middle of a search (R1)
    vin = 165;
    repeat (4) step();
    check("R1 mid-frame precondition cmpMode", int'(cmpMode), 1);
    rst = 1'b1;
    step();
    check("R1 mid-frame sampleEn", int'(sampleEn), 1);
    check("R1 mid-frame cmpMode", int'(cmpMode), 0);
    check("R1 mid-frame capCode", int'(capCode), 0);
    check("R1 mid-frame frameCount", int'(frameCount), 0);
    rst = 1'b0;
    runFrame(165, 0);
    runFrame(255, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule